// File: doc/BRIEF.md
# Masked BSSID Receive Acceptance Filter

This block decides, one frame at a time, whether the 48-bit BSSID carried by an incoming frame belongs to the station. The station is treated as the owner of that frame, and the frame is accepted for acknowledgement, when the BSSID agrees with the station's own MAC address on every bit position that a programmable mask marks as significant. Mask positions that are cleared are not compared. One filter can therefore cover a group of virtual BSSIDs that share their significant bits with the MAC. Software derives a suitable mask by AND-ing together NOT(mac XOR bssid) over every BSSID it serves. Some foreign BSSIDs that happen to agree on the masked bits are also accepted, and this is intended behaviour.

The MAC and the mask are each written through a 32-bit write port with byte strobes, split into a low word and an upper halfword. The register that holds the upper MAC halfword also holds a 16-bit control field for neighbouring logic. That field must be left intact when only the MAC halfword is written. Each frame is presented with a one-cycle strobe. The verdict is registered, so a new comparison can start on every clock.

Top module: `bssid_accept_filter`

## Requirements
- R1: When `accept_valid` is high, `accept` is 1 exactly when ((bssid XOR mac) AND mask) is zero, using the BSSID that was presented on the strobe one cycle earlier.
- R2: A bit position whose mask bit is 0 has no effect on the verdict. A BSSID that differs from the MAC only in such positions is accepted.
- R3: With an all-ones mask, only a BSSID equal to the MAC is accepted.
- R4: After reset the mask is all ones, the MAC is zero, `ctl_field` is zero and `accept_valid` is low. A BSSID of zero is therefore accepted and any other BSSID is rejected.
- R5: Register layout, byte k of each word on `reg_wdata[8k+7:8k]`. Address 0 holds MAC bits 31:0. Address 1 bits 15:0 hold MAC bits 47:32. Address 2 holds mask bits 31:0. Address 3 bits 15:0 hold mask bits 47:32, and writes to bits 31:16 of address 3 are ignored. BSSID bit i is compared with MAC bit i and is masked by mask bit i.
- R6: Bits 31:16 of address 1 form the control field shown on `ctl_field`. A write to address 1 with `reg_wstrb` = 4'b0011 replaces the upper MAC halfword and leaves `ctl_field` unchanged. A byte is written only when its strobe bit is set.
- R7: `accept_valid` is high exactly one cycle after each `frame_valid` cycle, so back-to-back strobes give back-to-back verdicts. `accept` is 0 whenever `accept_valid` is 0.
- R8: A register write in the same cycle as a frame strobe does not affect that frame's verdict. It does affect every frame strobed afterwards.
- R9: With a mask derived from a set of owned BSSIDs, a foreign BSSID that agrees with the MAC on the masked bits is accepted, and one that disagrees on a masked bit is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wstrb | input | 4 | Byte strobes for the write |
| reg_wdata | input | 32 | Write data |
| frame_valid | input | 1 | One-cycle strobe: a BSSID is presented for comparison |
| frame_bssid | input | 48 | BSSID of the incoming frame |
| accept_valid | output | 1 | Verdict valid, one cycle after `frame_valid` |
| accept | output | 1 | Frame accepted |
| ctl_field | output | 16 | Control bits that share a register with the upper MAC halfword |

## Verification
The hardest situation to create from the ports is a register write that lands in the very cycle a frame is strobed. In that cycle the old and the new configuration would give different verdicts. The bench issues a write and a strobe on the same edge, with the new MAC chosen so the frame would be rejected under the new value, and then strobes the same BSSID again. Over-acceptance is reached by computing a mask from two owned BSSIDs inside the bench and then sending a foreign BSSID built to agree only on the masked bits.

// File: rtl/bssid_filt_pkg.sv
package bssid_filt_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * 8;
    localparam int BUS_W       = 32;
    localparam int LANES       = BUS_W / 8;
    localparam int REG_AW      = 2;
    localparam int CTL_BYTES   = 2;
    localparam int CTL_W       = CTL_BYTES * 8;
    localparam int MASK_BASE   = ADDR_BYTES;
    localparam int CTL_BASE    = 2 * ADDR_BYTES;
    localparam int STORE_BYTES = CTL_BASE + CTL_BYTES;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        addr_t            mask;
        addr_t            mac;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    localparam logic [REG_AW-1:0] RA_MAC_LO = 2'd0;
    localparam logic [REG_AW-1:0] RA_MAC_HI = 2'd1;
    localparam logic [REG_AW-1:0] RA_MSK_LO = 2'd2;
    localparam logic [REG_AW-1:0] RA_MSK_HI = 2'd3;

    // Which register word owns storage byte b.
    function automatic logic [REG_AW-1:0] byte_reg(int b);
        if (b < LANES)                  return RA_MAC_LO;
        else if (b < MASK_BASE)         return RA_MAC_HI;
        else if (b < MASK_BASE + LANES) return RA_MSK_LO;
        else if (b < CTL_BASE)          return RA_MSK_HI;
        else                            return RA_MAC_HI;
    endfunction

    // Which byte lane of that word carries storage byte b.
    function automatic int byte_lane(int b);
        if (b < LANES)                  return b;
        else if (b < MASK_BASE)         return b - LANES;
        else if (b < MASK_BASE + LANES) return b - MASK_BASE;
        else if (b < CTL_BASE)          return b - MASK_BASE - LANES;
        else                            return b - CTL_BASE + (LANES - CTL_BYTES);
    endfunction

    // Reset value: mask bytes all ones (exact match), everything else zero.
    function automatic logic [7:0] byte_rst(int b);
        return (b >= MASK_BASE && b < CTL_BASE) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic masked_hit(addr_t id, addr_t own, addr_t msk);
        return ((id ^ own) & msk) == '0;
    endfunction

endpackage

// File: rtl/bssid_filt_regs.sv
module bssid_filt_regs
    import bssid_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_strb,
    input  logic [BUS_W-1:0]  wr_data,
    output cfg_t              cfg
);

    logic [STORE_BYTES-1:0][7:0] store;

    // One flop byte per stored field byte; unused register lanes get no storage.
    for (genvar b = 0; b < STORE_BYTES; b++) begin : g_byte
        localparam logic [REG_AW-1:0] OWNER = byte_reg(b);
        localparam int                LANE  = byte_lane(b);
        always_ff @(posedge clk) begin
            if (rst)
                store[b] <= byte_rst(b);
            else if (wr_en && wr_addr == OWNER && wr_strb[LANE])
                store[b] <= wr_data[LANE*8 +: 8];
        end
    end

    assign cfg.mac  = store[MASK_BASE-1:0];
    assign cfg.mask = store[CTL_BASE-1:MASK_BASE];
    assign cfg.ctl  = store[STORE_BYTES-1:CTL_BASE];

    // R6: writing only the MAC halfword of the shared word keeps the control field
    a_r6_ctl_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_MAC_HI && wr_strb[LANES-1 -: CTL_BYTES] == '0)
        |=> $stable(cfg.ctl));

    // R4: configuration right after reset
    a_r4_reset_cfg: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.mask == '1 && cfg.mac == '0 && cfg.ctl == '0));

    // R5: upper lanes of the mask halfword never change the configuration
    a_r5_msk_hi_upper_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_MSK_HI && wr_strb[CTL_BYTES-1:0] == '0) |=> $stable(cfg));

endmodule

// File: rtl/bssid_filt_compare.sv
module bssid_filt_compare
    import bssid_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_valid,
    input  addr_t    frame_bssid,
    input  addr_t    own_mac,
    input  addr_t    own_mask,
    output verdict_t verdict
);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.valid  <= frame_valid;
            verdict.accept <= frame_valid && masked_hit(frame_bssid, own_mac, own_mask);
        end
    end

    // R7: every strobe gets a verdict on the next cycle
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> verdict.valid);

    // R7: no accept without a valid verdict
    a_r7_no_stray_accept: assert property (@(posedge clk) disable iff (rst)
        !verdict.valid |-> !verdict.accept);

    // R1: a BSSID equal to the own MAC is always accepted
    a_r1_own_mac_hit: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_bssid == own_mac) |=> verdict.accept);

    // R3: a full mask admits only the exact MAC
    a_r3_exact_only: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && own_mask == '1 && frame_bssid != own_mac) |=> !verdict.accept);

endmodule

// File: rtl/bssid_accept_filter.sv
module bssid_accept_filter
    import bssid_filt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [LANES-1:0]      reg_wstrb,
    input  logic [BUS_W-1:0]      reg_wdata,
    input  logic                  frame_valid,
    input  logic [ADDR_W-1:0]     frame_bssid,
    output logic                  accept_valid,
    output logic                  accept,
    output logic [CTL_W-1:0]      ctl_field
);

    cfg_t     cfg;
    verdict_t verdict;

    bssid_filt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_strb (reg_wstrb),
        .wr_data (reg_wdata),
        .cfg     (cfg)
    );

    // The comparison sees the configuration before any write on the same edge (R8).
    bssid_filt_compare u_cmp (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame_bssid (frame_bssid),
        .own_mac     (cfg.mac),
        .own_mask    (cfg.mask),
        .verdict     (verdict)
    );

    assign accept_valid = verdict.valid;
    assign accept       = verdict.accept;
    assign ctl_field    = cfg.ctl;

endmodule

// File: tb/bssid_accept_filter_tb.sv
module bssid_accept_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [1:0]  reg_addr;
    logic [3:0]  reg_wstrb;
    logic [31:0] reg_wdata;
    logic        frame_valid;
    logic [47:0] frame_bssid;
    logic        accept_valid;
    logic        accept;
    logic [15:0] ctl_field;

    always #5 clk = ~clk;

    bssid_accept_filter u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata),
        .frame_valid(frame_valid), .frame_bssid(frame_bssid),
        .accept_valid(accept_valid), .accept(accept), .ctl_field(ctl_field)
    );

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    // bench model of the configuration
    logic [47:0] m_mac;
    logic [47:0] m_mask;
    logic [15:0] m_ctl;

    function automatic logic ref_accept(logic [47:0] id);
        for (int i = 0; i < 48; i++)
            if (m_mask[i] && (id[i] != m_mac[i])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_write(logic [1:0] a, logic [3:0] s, logic [31:0] d);
        for (int l = 0; l < 4; l++) begin
            if (s[l]) begin
                case (a)
                    2'd0: m_mac[l*8 +: 8]  = d[l*8 +: 8];
                    2'd1: if (l < 2) m_mac[32 + l*8 +: 8] = d[l*8 +: 8];
                          else       m_ctl[(l-2)*8 +: 8]  = d[l*8 +: 8];
                    2'd2: m_mask[l*8 +: 8] = d[l*8 +: 8];
                    default: if (l < 2) m_mask[32 + l*8 +: 8] = d[l*8 +: 8];
                endcase
            end
        end
    endtask

    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; leaves the next negedge current
    task automatic reg_write(logic [1:0] a, logic [3:0] s, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
        model_write(a, s, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic send(logic [47:0] b, string tag);
        exp_t e;
        e.exp = ref_accept(b);
        e.tag = tag;
        q.push_back(e);
        frame_valid = 1'b1; frame_bssid = b;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    // R8: write and strobe on the same edge; the frame is judged on the old model
    task automatic send_with_write(logic [47:0] b, logic [1:0] a, logic [3:0] s, logic [31:0] d, string tag);
        exp_t e;
        e.exp = ref_accept(b);
        e.tag = tag;
        q.push_back(e);
        frame_valid = 1'b1; frame_bssid = b;
        reg_wr_en = 1'b1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
        model_write(a, s, d);
        @(negedge clk);
        frame_valid = 1'b0; reg_wr_en = 1'b0;
    endtask

    task automatic set_mac(logic [47:0] v);
        reg_write(2'd0, 4'hF, v[31:0]);
        reg_write(2'd1, 4'h3, {16'h0, v[47:32]});
    endtask

    task automatic set_mask(logic [47:0] v);
        reg_write(2'd2, 4'hF, v[31:0]);
        reg_write(2'd3, 4'hF, {16'hFFFF, v[47:32]});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (accept_valid) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R7 unexpected verdict actual=%b expected=none", accept);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, {47'd0, accept}, {47'd0, e.exp});
                end
            end else if (accept) begin
                n_chk++; n_bad++;
                $display("FAIL R7 accept without valid actual=1 expected=0");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] own, b1, b2, mk, foreign;
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wstrb = '0; reg_wdata = '0;
        frame_valid = 1'b0; frame_bssid = '0;
        m_mac = '0; m_mask = '1; m_ctl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        check("R4 accept_valid after reset", {47'd0, accept_valid}, 48'd0);
        check("R4 ctl_field after reset", {32'd0, ctl_field}, 48'd0);
        send(48'h0, "R4 zero bssid accepted");
        send(48'h1, "R4 nonzero bssid rejected");
        @(negedge clk);

        // R5/R3: program MAC, exact match under full mask
        own = 48'h0A1B_2C3D_4E5F;
        set_mac(own);
        send(own, "R3 exact match accepted");
        send(own ^ 48'h8000_0000_0000, "R3 top bit differs rejected");
        send(own ^ 48'h0000_0000_0001, "R3 low bit differs rejected");
        send(own ^ 48'h0000_0001_0000, "R5 bit 16 differs rejected");
        @(negedge clk);

        // R6: control field set, then MAC halfword rewrite preserves it
        reg_write(2'd1, 4'hC, 32'hBEEF_0000);
        check("R6 ctl_field written", {32'd0, ctl_field}, {32'd0, m_ctl});
        check("R6 ctl_field value", {32'd0, ctl_field}, 48'h0000_0000_BEEF);
        reg_write(2'd1, 4'h3, 32'h1234_5566);
        check("R6 ctl_field kept", {32'd0, ctl_field}, 48'h0000_0000_BEEF);
        own = {16'h5566, own[31:0]};
        send(own, "R6 new MAC halfword takes effect");
        // R6: single strobe lane only
        reg_write(2'd0, 4'h2, 32'hFFFF_77FF);
        own[15:8] = 8'h77;
        send(own, "R6 single byte strobe");
        send({own[47:16], 8'hFF, own[7:0]}, "R6 unstrobed bytes untouched");
        @(negedge clk);

        // R2/R9: mask derived from two owned BSSIDs
        b1 = own ^ 48'h0000_0F00_0003;
        b2 = own ^ 48'hC000_0000_0300;
        mk = ~(own ^ b1) & ~(own ^ b2);
        set_mask(mk);
        check("R5 upper mask lanes ignored", {47'd0, ctl_field == 16'hBEEF}, 48'd1);
        send(b1, "R2 owned bssid 1 accepted");
        send(b2, "R2 owned bssid 2 accepted");
        foreign = own ^ 48'hC000_0F00_0303;
        send(foreign, "R9 foreign on unmasked bits accepted");
        send(own ^ 48'h0000_0000_0010, "R9 masked bit differs rejected");
        send(own ^ 48'h0100_0000_0000, "R1 high masked bit differs rejected");
        @(negedge clk);

        // R1: mask of zero accepts everything
        set_mask(48'h0);
        send(48'hFFFF_FFFF_FFFF, "R1 empty mask accepts all");
        send(48'h1234_0000_9876, "R1 empty mask accepts other");
        set_mask(48'hFFFF_FFFF_FFFF);

        // R8: write coincides with strobe
        send_with_write(own, 2'd0, 4'h1, {24'h0, own[7:0] ^ 8'h01}, "R8 same-cycle write not applied");
        send(own, "R8 later frame sees new MAC");
        own[7:0] = own[7:0] ^ 8'h01;
        send(own, "R8 new MAC matches");
        @(negedge clk);
        @(negedge clk);

        check("R7 all verdicts returned", q.size(), 48'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule